// File: doc/BRIEF.md
# Serial Controller Register Interface

This block is the processor-facing register file of a byte-oriented serial controller in the style of the common 16550 family. A processor reaches it through a simple byte bus: a select strobe, a direction bit, an 8-bit address and 8-bit write data. Read data comes back combinationally in the same cycle. Only the three low address bits pick one of eight registers, so the block can sit anywhere in a 256-byte window and repeat across it.

On the serial side the block exposes two things. The head of a 16-entry transmit queue is offered on a valid/ready port, and a 16-entry receive queue is filled from a second valid/ready port. It also drives the 16-bit baud divisor, the modem control byte and an interrupt request line. It samples a modem status byte for read-back.

Offsets 0 and 1 change meaning with bit 7 of the line control register, the divisor access bit. When that bit is set they reach the two divisor bytes, and the data queues and the interrupt enable register are left alone.

Top module: `uart_regfile`

## Requirements
- R1: After reset, line control, interrupt enable, modem control, scratch and both divisor bytes are 0, both queues are empty, line status reads 0x20, interrupt identification reads 0x01 and `irq_o` is low.
- R2: With line control bit 7 clear, a write at offset 0 appends the byte to the transmit queue. Bytes leave on `tx_data_o` in write order, one per cycle in which `tx_valid_o` and `tx_ready_i` are both high.
- R3: With line control bit 7 clear, a read at offset 0 returns the oldest received byte and removes it. A read at offset 0 while the receive queue is empty returns 0x00 and changes nothing.
- R4: With line control bit 7 set, offset 0 reads and writes the low divisor byte and offset 1 the high divisor byte, and `divisor_o` = {high, low}. Such accesses leave both queues and the interrupt enable register unchanged.
- R5: Line status bit 5 is 1 exactly when the transmit queue holds fewer than 16 bytes. A transmit write while the queue is full is dropped and sets line status bit 1, which stays set until line status (offset 5) is read.
- R6: Line status bit 0 is 1 exactly while the receive queue is non-empty. `rx_ready_o` is low exactly when the receive queue holds 16 bytes.
- R7: `irq_o` is high exactly when interrupt enable bit 0 is set and received data is present. Interrupt identification (offset 2 read) then reads 0x04, and otherwise 0x01.
- R8: A write at offset 2 with bit 1 set empties the receive queue, and with bit 2 set empties the transmit queue. These bits take effect once and are not stored.
- R9: Only address bits [2:0] select a register. Offset 1 with line control bit 7 clear is the interrupt enable register (bits 3:0 stored). Offset 3 is line control, offset 4 modem control (`mcr_o`), offset 6 returns `msr_i`, and offset 7 is a read/write scratch byte. Writes to offsets 5 and 6 have no effect.
- R10: Each queue holds exactly 16 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address inside the window |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle of the access |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_valid_o | output | 1 | Transmit queue non-empty |
| tx_ready_i | input | 1 | Serial side takes the byte |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte present |
| rx_ready_o | output | 1 | Receive queue has room |
| divisor_o | output | 16 | Baud divisor |
| mcr_o | output | 8 | Modem control byte |
| msr_i | input | 8 | Modem status byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a transmit write that arrives while the queue is full. The bench holds `tx_ready_i` low and writes seventeen bytes, so the last one meets a full queue. It then checks that line status bit 1 sets and clears on the next status read, and that exactly sixteen bytes drain in order. A second hard case is a divisor-mode read at offset 0 while received data waits. The bench parks a received byte, sets the divisor access bit, reads offset 0, and then shows through line status and a later receive read that the byte is still there.

// File: rtl/uart_regfile_pkg.sv
package uart_regfile_pkg;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IER  = 3'd1;
  localparam logic [2:0] OFS_IIR  = 3'd2;
  localparam logic [2:0] OFS_LCR  = 3'd3;
  localparam logic [2:0] OFS_MCR  = 3'd4;
  localparam logic [2:0] OFS_LSR  = 3'd5;
  localparam logic [2:0] OFS_MSR  = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  localparam logic [7:0] IIR_NONE   = 8'h01;
  localparam logic [7:0] IIR_RXDATA = 8'h04;

  typedef struct packed {
    logic thr_wr;
    logic dll_wr;
    logic dlm_wr;
    logic ier_wr;
    logic fcr_wr;
    logic lcr_wr;
    logic mcr_wr;
    logic scr_wr;
    logic rbr_rd;
    logic lsr_rd;
  } strobe_t;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign rdata_o = mem_q[rd_ptr_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= next_ptr(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= next_ptr(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_ptr_q] <= wdata_i;
  end
endmodule

// File: rtl/uart_addr_decode.sv
module uart_addr_decode
  import uart_regfile_pkg::*;
(
  input  logic       req_i,
  input  logic       we_i,
  input  logic [2:0] ofs_i,
  input  logic       dlab_i,
  output strobe_t    strobe_o
);
  logic wr, rd;
  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  always_comb begin
    strobe_o        = '0;
    strobe_o.thr_wr = wr && (ofs_i == OFS_DATA) && !dlab_i;
    strobe_o.dll_wr = wr && (ofs_i == OFS_DATA) && dlab_i;
    strobe_o.ier_wr = wr && (ofs_i == OFS_IER) && !dlab_i;
    strobe_o.dlm_wr = wr && (ofs_i == OFS_IER) && dlab_i;
    strobe_o.fcr_wr = wr && (ofs_i == OFS_IIR);
    strobe_o.lcr_wr = wr && (ofs_i == OFS_LCR);
    strobe_o.mcr_wr = wr && (ofs_i == OFS_MCR);
    strobe_o.scr_wr = wr && (ofs_i == OFS_SCR);
    strobe_o.rbr_rd = rd && (ofs_i == OFS_DATA) && !dlab_i;
    strobe_o.lsr_rd = rd && (ofs_i == OFS_LSR);
  end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_regfile_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_valid_o,
  input  logic        tx_ready_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_valid_i,
  output logic        rx_ready_o,
  output logic [15:0] divisor_o,
  output logic [7:0]  mcr_o,
  input  logic [7:0]  msr_i,
  output logic        irq_o
);
  logic [7:0] lcr_q, mcr_q, scr_q, dll_q, dlm_q;
  logic [3:0] ier_q;
  logic       tx_drop_q;
  strobe_t    stb;
  logic       dlab;
  logic [7:0] rx_head, lsr_val, iir_val;
  logic       tx_full, tx_empty, rx_full, rx_empty;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic       flush_rx, flush_tx;

  assign dlab = lcr_q[7];

  uart_addr_decode u_dec (
    .req_i   (req_i),
    .we_i    (we_i),
    .ofs_i   (addr_i[2:0]),
    .dlab_i  (dlab),
    .strobe_o(stb)
  );

  // FCR bits act as one-shot pulses
  assign flush_rx = stb.fcr_wr && wdata_i[1];
  assign flush_tx = stb.fcr_wr && wdata_i[2];

  uart_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_tx_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush_tx),
    .push_i (stb.thr_wr),
    .wdata_i(wdata_i),
    .pop_i  (tx_ready_i),
    .rdata_o(tx_data_o),
    .full_o (tx_full),
    .empty_o(tx_empty),
    .count_o(tx_cnt)
  );

  uart_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rx_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush_rx),
    .push_i (rx_valid_i),
    .wdata_i(rx_data_i),
    .pop_i  (stb.rbr_rd),
    .rdata_o(rx_head),
    .full_o (rx_full),
    .empty_o(rx_empty),
    .count_o(rx_cnt)
  );

  assign tx_valid_o = !tx_empty;
  assign rx_ready_o = !rx_full;
  assign divisor_o  = {dlm_q, dll_q};
  assign mcr_o      = mcr_q;
  assign irq_o      = ier_q[0] && !rx_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q     <= '0;
      mcr_q     <= '0;
      scr_q     <= '0;
      dll_q     <= '0;
      dlm_q     <= '0;
      ier_q     <= '0;
      tx_drop_q <= 1'b0;
    end else begin
      if (stb.lcr_wr) lcr_q <= wdata_i;
      if (stb.mcr_wr) mcr_q <= wdata_i;
      if (stb.scr_wr) scr_q <= wdata_i;
      if (stb.dll_wr) dll_q <= wdata_i;
      if (stb.dlm_wr) dlm_q <= wdata_i;
      if (stb.ier_wr) ier_q <= wdata_i[3:0];
      // set wins over clear-on-read
      if (stb.thr_wr && tx_full) tx_drop_q <= 1'b1;
      else if (stb.lsr_rd)       tx_drop_q <= 1'b0;
    end
  end

  always_comb begin
    lsr_val    = '0;
    lsr_val[0] = !rx_empty;
    lsr_val[1] = tx_drop_q;
    lsr_val[5] = !tx_full;
    iir_val    = (ier_q[0] && !rx_empty) ? IIR_RXDATA : IIR_NONE;
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      case (addr_i[2:0])
        OFS_DATA: rdata_o = dlab ? dll_q : (rx_empty ? 8'h00 : rx_head);
        OFS_IER:  rdata_o = dlab ? dlm_q : {4'h0, ier_q};
        OFS_IIR:  rdata_o = iir_val;
        OFS_LCR:  rdata_o = lcr_q;
        OFS_MCR:  rdata_o = mcr_q;
        OFS_LSR:  rdata_o = lsr_val;
        OFS_MSR:  rdata_o = msr_i;
        default:  rdata_o = scr_q;
      endcase
    end
  end
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [7:0]    addr_i,
  input logic [7:0]    wdata_i,
  input logic [7:0]    rdata_o,
  input logic          tx_valid_o,
  input logic          rx_valid_i,
  input logic          rx_ready_o,
  input logic [15:0]   divisor_o,
  input logic          irq_o,
  input logic          dlab,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [7:0]    iir_val
);
  // R7
  irq_iir_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (iir_val == 8'h04));

  // R6
  rx_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> (rx_cnt < CW'(DEPTH)));

  // R10
  tx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt <= CW'(DEPTH));

  // R3
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[2:0] == 3'd0 && !dlab && rx_cnt == '0 && !rx_valid_i)
      |-> (rdata_o == 8'h00) ##1 (rx_cnt == '0));

  // R4
  div_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[2:0] == 3'd0 && dlab) |=> (divisor_o[7:0] == $past(wdata_i)));

  // R8
  tx_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[2:0] == 3'd2 && wdata_i[2]) |=> !tx_valid_o);
endmodule

bind uart_regfile uart_regfile_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .tx_valid_o(tx_valid_o),
  .rx_valid_i(rx_valid_i),
  .rx_ready_o(rx_ready_o),
  .divisor_o (divisor_o),
  .irq_o     (irq_o),
  .dlab      (dlab),
  .tx_cnt    (tx_cnt),
  .rx_cnt    (rx_cnt),
  .iir_val   (iir_val)
);

// File: tb/tb_uart_regfile.sv
module tb_uart_regfile;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic [7:0] tx_data, rx_data = '0, msr = 8'h5a, mcr;
  logic tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready, irq;
  logic [15:0] divisor;

  int total = 0, bad = 0;
  logic [7:0] tx_exp[$];
  logic [7:0] rx_exp[$];

  always #2 clk = ~clk;

  uart_regfile dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .rx_ready_o(rx_ready), .divisor_o(divisor), .mcr_o(mcr), .msr_i(msr), .irq_o(irq)
  );

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic cpu_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  // driver: transmit write, with scoreboard entry when accepted
  task automatic thr_write(input logic [7:0] d, input bit accepted);
    cpu_write(8'h00, d);
    if (accepted) tx_exp.push_back(d);
  endtask

  task automatic rx_send(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(posedge clk); #1;
    rx_valid = 1'b0;
    rx_exp.push_back(d);
  endtask

  task automatic rbr_read_check(input string tag);
    logic [7:0] v;
    logic [7:0] e;
    cpu_read(8'h00, v);
    e = (rx_exp.size() > 0) ? rx_exp.pop_front() : 8'h00;
    check(tag, v, e);
  endtask

  // monitor: compare transmit bytes against scoreboard
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (tx_exp.size() == 0) check("R2 unexpected tx byte", tx_data, 8'hxx);
      else check("R2 tx order", tx_data, tx_exp.pop_front());
    end
  end

  initial begin
    #(4 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    cpu_read(8'h05, v); check("R1 lsr", v, 8'h20);
    cpu_read(8'h02, v); check("R1 iir", v, 8'h01);
    cpu_read(8'h03, v); check("R1 lcr", v, 8'h00);
    cpu_read(8'h01, v); check("R1 ier", v, 8'h00);
    check("R1 divisor", divisor, 16'h0);
    check("R1 irq", irq, 1'b0);

    // R9 aliasing and plain registers
    cpu_write(8'h07, 8'ha5);
    cpu_read(8'h3f, v); check("R9 scratch alias", v, 8'ha5);
    cpu_write(8'hc4, 8'h13);
    cpu_read(8'h04, v); check("R9 mcr read", v, 8'h13);
    check("R9 mcr_o", mcr, 8'h13);
    cpu_read(8'h06, v); check("R9 msr", v, 8'h5a);
    cpu_write(8'h05, 8'hff);
    cpu_write(8'h06, 8'hff);
    cpu_read(8'h05, v); check("R9 lsr write ignored", v, 8'h20);
    cpu_write(8'h01, 8'hf6);
    cpu_read(8'h01, v); check("R9 ier width", v, 8'h06);
    cpu_write(8'h01, 8'h00);

    // R4 divisor access
    cpu_write(8'h03, 8'h83);
    cpu_write(8'h00, 8'h34);
    cpu_write(8'h01, 8'h12);
    check("R4 divisor", divisor, 16'h1234);
    cpu_read(8'h00, v); check("R4 dll read", v, 8'h34);
    cpu_read(8'h01, v); check("R4 dlm read", v, 8'h12);
    check("R4 tx untouched", tx_valid, 1'b0);
    cpu_write(8'h03, 8'h03);
    cpu_read(8'h01, v); check("R4 ier untouched", v, 8'h00);

    // R2 transmit order
    tx_ready = 1'b1;
    thr_write(8'h11, 1); thr_write(8'h22, 1); thr_write(8'h33, 1);
    repeat (6) @(posedge clk);
    check("R2 drained", tx_exp.size(), 0);

    // R5 / R10 full transmit queue
    tx_ready = 1'b0;
    for (int i = 0; i < 15; i++) thr_write(8'h40 + 8'(i), 1);
    cpu_read(8'h05, v); check("R5 room at 15", v[5], 1'b1);
    thr_write(8'h4f, 1);
    cpu_read(8'h05, v); check("R10 full at 16", v[5], 1'b0);
    thr_write(8'hee, 0);
    cpu_read(8'h05, v); check("R5 drop flag set", v, 8'h02);
    cpu_read(8'h05, v); check("R5 drop flag cleared", v, 8'h00);
    tx_ready = 1'b1;
    repeat (20) @(posedge clk);
    check("R10 sixteen drained", tx_exp.size(), 0);
    check("R5 queue empty", tx_valid, 1'b0);

    // R3 receive path
    rbr_read_check("R3 empty read");
    cpu_read(8'h05, v); check("R3 empty no effect", v[0], 1'b0);
    rx_send(8'ha1); rx_send(8'hb2); rx_send(8'hc3);
    cpu_read(8'h05, v); check("R6 data present", v[0], 1'b1);
    rbr_read_check("R3 rx 1"); rbr_read_check("R3 rx 2"); rbr_read_check("R3 rx 3");
    cpu_read(8'h05, v); check("R6 drained", v[0], 1'b0);

    // R4 divisor read does not pop
    rx_send(8'h5c);
    cpu_write(8'h03, 8'h80);
    cpu_read(8'h00, v); check("R4 dll while rx data", v, 8'h34);
    cpu_write(8'h03, 8'h00);
    cpu_read(8'h05, v); check("R4 rx kept", v[0], 1'b1);
    rbr_read_check("R4 rx byte intact");

    // R6 / R10 receive full
    for (int i = 0; i < 16; i++) rx_send(8'h80 + 8'(i));
    check("R6 rx_ready low when full", rx_ready, 1'b0);

    // R7 interrupt
    check("R7 irq masked", irq, 1'b0);
    cpu_write(8'h01, 8'h01);
    check("R7 irq", irq, 1'b1);
    cpu_read(8'h02, v); check("R7 iir rx", v, 8'h04);
    cpu_write(8'h01, 8'h00);
    cpu_read(8'h02, v); check("R7 iir none", v, 8'h01);

    // R8 flushes
    cpu_write(8'h02, 8'h02);
    rx_exp.delete();
    cpu_read(8'h05, v); check("R8 rx flushed", v[0], 1'b0);
    check("R8 rx ready", rx_ready, 1'b1);
    tx_ready = 1'b0;
    thr_write(8'h01, 0); thr_write(8'h02, 0); thr_write(8'h03, 0);
    check("R8 tx loaded", tx_valid, 1'b1);
    cpu_write(8'h02, 8'h04);
    check("R8 tx flushed", tx_valid, 1'b0);
    tx_ready = 1'b1;
    repeat (4) @(posedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule